// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of a single-precision fused multiply-add datapath. The datapath computes z + x*y, or z - x*y when the negate-product control is high. The resolver sorts each of the three operands into one of six classes: signalling NaN, quiet NaN, infinity, zero, denormal or normal. From those classes it decides whether the final result is already fixed by the operand classes alone. When it is, the block presents that result, a hit flag and an invalid-operation flag. When it is not, the hit flag stays low and the datapath carries on with the real arithmetic.

All outputs are registered, so a decision appears one clock after its operands are presented, and a new operand set can be accepted every cycle. A round-toward-negative mode bit is also taken in. It matters in one place only: when exact zeros of opposite effective sign cancel, it picks the sign of the zero. Denormal operands are treated as finite nonzero values and are never flushed.

Top module: `fma_special_stage`

## Requirements
- R1: While reset is high, and on the first cycle after it, the hit flag, the invalid flag and the result are all zero. In normal operation every output reflects the operands sampled at the previous rising edge.
- R2: Any signalling NaN operand wins over any quiet NaN operand, wherever each one sits. Among several signalling NaNs, z wins over x and x wins over y. A NaN has exponent bits 30:23 all ones and a nonzero mantissa. It is quiet when mantissa bit 22 is set and signalling when bit 22 is clear.
- R3: A winning signalling NaN gives hit=1 and invalid=1. The result is that operand with bit 22 set and every other bit unchanged.
- R4: With no signalling NaN present, the first quiet NaN in the order z, x, y is output unchanged, with hit=1 and invalid=0.
- R5: With no NaN present, a product of infinity and zero, in either operand order, gives hit=1, invalid=1 and the result 0x7FC00000.
- R6: The effective product sign is sign(x) XOR sign(y), inverted when negate-product is high. An infinite product combined with an infinite z of the other effective sign gives hit=1, invalid=1 and 0x7FC00000.
- R7: In every other case where the product is infinite, the result is an infinity carrying the effective product sign: 0x7F800000 or 0xFF800000. Invalid is 0.
- R8: A zero product, with no NaN and no infinite factor, gives the z operand unchanged when z is infinite, normal or denormal. Invalid is 0.
- R9: A zero product with a zero z returns z when the effective product sign equals the sign of z. When the signs differ, the result is +0 (0x00000000), or -0 (0x80000000) when the round-toward-negative bit is high.
- R10: A finite nonzero product with an infinite z gives z's infinity, with invalid=0.
- R11: When no rule above applies (finite nonzero product and finite z), hit, invalid and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| z_op | input | 32 | Addend operand |
| x_op | input | 32 | First multiplicand |
| y_op | input | 32 | Second multiplicand |
| neg_product | input | 1 | Subtract the product instead of adding it |
| round_neg | input | 1 | Rounding mode is toward negative infinity |
| special_hit | output | 1 | Result is fixed by a special case |
| special_val | output | 32 | The fixed result, zero when no hit |
| invalid_op | output | 1 | Invalid-operation exception raised |

## Verification
The block holds no state beyond its output register, so an internal fault cannot build up over time. A wrong class decode or a wrong priority shows at the ports on the very next cycle, for the operand set that provoked it. The most sensitive cases are NaN contests between operand positions, and sign comparisons in which one flipped bit turns an infinity into the default NaN or changes the sign of a zero. The stimulus therefore pairs each such case with a neighbour that differs in only one sign, mode or operand position.

// File: rtl/fma_sp_pkg.sv
package fma_sp_pkg;
  typedef enum logic [2:0] {
    CL_ZERO   = 3'd0,
    CL_DENORM = 3'd1,
    CL_NORMAL = 3'd2,
    CL_INF    = 3'd3,
    CL_QNAN   = 3'd4,
    CL_SNAN   = 3'd5
  } fp_class_e;

  localparam int unsigned OPERAND_CNT = 3;
  localparam int unsigned IDX_Z = 0;
  localparam int unsigned IDX_X = 1;
  localparam int unsigned IDX_Y = 2;
endpackage

// File: rtl/fma_operand_classify.sv
module fma_operand_classify
  import fma_sp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op,
  output fp_class_e            cls,
  output logic                 sgn
);
  localparam int unsigned W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             exp_min;

  assign exp_f   = op[W-2:MAN_W];
  assign man_f   = op[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign sgn     = op[W-1];

  always_comb begin
    if (exp_max) begin
      if (man_f == '0)            cls = CL_INF;
      else if (man_f[MAN_W-1])    cls = CL_QNAN;
      else                        cls = CL_SNAN;
    end else if (exp_min) begin
      cls = (man_f == '0) ? CL_ZERO : CL_DENORM;
    end else begin
      cls = CL_NORMAL;
    end
  end
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fma_sp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [OPERAND_CNT-1:0][EXP_W+MAN_W:0] ops,
  input  fp_class_e                             cls [OPERAND_CNT],
  input  logic [OPERAND_CNT-1:0]                sgn,
  input  logic                                  neg_product,
  input  logic                                  round_neg,
  output logic                                  hit,
  output logic                                  inv,
  output logic [EXP_W+MAN_W:0]                  val
);
  localparam int unsigned W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic         snan_found, qnan_found;
  logic [W-1:0] snan_pick, qnan_pick;
  logic         prod_sign;
  logic         prod_inf, prod_zero, z_inf, z_zero;

  // Scan from the last operand to the first so the earliest one wins.
  always_comb begin
    snan_found = 1'b0;
    qnan_found = 1'b0;
    snan_pick  = '0;
    qnan_pick  = '0;
    for (int i = OPERAND_CNT - 1; i >= 0; i--) begin
      if (cls[i] == CL_SNAN) begin
        snan_found = 1'b1;
        snan_pick  = ops[i];
      end
      if (cls[i] == CL_QNAN) begin
        qnan_found = 1'b1;
        qnan_pick  = ops[i];
      end
    end
  end

  assign prod_sign = sgn[IDX_X] ^ sgn[IDX_Y] ^ neg_product;
  assign prod_inf  = (cls[IDX_X] == CL_INF) || (cls[IDX_Y] == CL_INF);
  assign prod_zero = (cls[IDX_X] == CL_ZERO) || (cls[IDX_Y] == CL_ZERO);
  assign z_inf     = (cls[IDX_Z] == CL_INF);
  assign z_zero    = (cls[IDX_Z] == CL_ZERO);

  always_comb begin
    hit = 1'b0;
    inv = 1'b0;
    val = '0;
    if (snan_found) begin
      hit = 1'b1;
      inv = 1'b1;
      val = snan_pick | QUIET_BIT;
    end else if (qnan_found) begin
      hit = 1'b1;
      val = qnan_pick;
    end else if (prod_inf) begin
      hit = 1'b1;
      if (prod_zero || (z_inf && (sgn[IDX_Z] != prod_sign))) begin
        inv = 1'b1;
        val = DEFAULT_NAN;
      end else begin
        val = {prod_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      end
    end else if (prod_zero) begin
      hit = 1'b1;
      if (z_zero && (sgn[IDX_Z] != prod_sign)) val = {round_neg, {(W-1){1'b0}}};
      else                                      val = ops[IDX_Z];
    end else if (z_inf) begin
      hit = 1'b1;
      val = ops[IDX_Z];
    end
  end
endmodule

// File: rtl/fma_special_stage.sv
module fma_special_stage
  import fma_sp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [EXP_W+MAN_W:0]   z_op,
  input  logic [EXP_W+MAN_W:0]   x_op,
  input  logic [EXP_W+MAN_W:0]   y_op,
  input  logic                   neg_product,
  input  logic                   round_neg,
  output logic                   special_hit,
  output logic [EXP_W+MAN_W:0]   special_val,
  output logic                   invalid_op
);
  localparam int unsigned W = 1 + EXP_W + MAN_W;

  logic [OPERAND_CNT-1:0][W-1:0] ops;
  fp_class_e                     cls [OPERAND_CNT];
  logic [OPERAND_CNT-1:0]        sgn;
  logic                          hit_c, inv_c;
  logic [W-1:0]                  val_c;

  assign ops[IDX_Z] = z_op;
  assign ops[IDX_X] = x_op;
  assign ops[IDX_Y] = y_op;

  for (genvar g = 0; g < OPERAND_CNT; g++) begin : g_cls
    fma_operand_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (ops[g]),
      .cls (cls[g]),
      .sgn (sgn[g])
    );
  end

  fma_special_resolve #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_res (
    .ops         (ops),
    .cls         (cls),
    .sgn         (sgn),
    .neg_product (neg_product),
    .round_neg   (round_neg),
    .hit         (hit_c),
    .inv         (inv_c),
    .val         (val_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      special_hit <= 1'b0;
      invalid_op  <= 1'b0;
      special_val <= '0;
    end else begin
      special_hit <= hit_c;
      invalid_op  <= inv_c;
      special_val <= val_c;
    end
  end
endmodule

// File: rtl/fma_special_stage_chk.sv
module fma_special_stage_chk #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic [EXP_W+MAN_W:0] z_op,
  input logic [EXP_W+MAN_W:0] x_op,
  input logic [EXP_W+MAN_W:0] y_op,
  input logic                 special_hit,
  input logic [EXP_W+MAN_W:0] special_val,
  input logic                 invalid_op
);
  localparam int unsigned W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QB = W'(1) << (MAN_W - 1);

  function automatic logic is_nan(input logic [W-1:0] v);
    return (&v[W-2:MAN_W]) && (v[MAN_W-1:0] != '0);
  endfunction
  function automatic logic is_inf(input logic [W-1:0] v);
    return (&v[W-2:MAN_W]) && (v[MAN_W-1:0] == '0);
  endfunction
  function automatic logic is_zero(input logic [W-2:0] v);
    return v == '0;
  endfunction

  logic z_sn, x_sn, y_sn, z_qn, any_sn, prod_fin_nz;
  assign z_sn   = is_nan(z_op) && !z_op[MAN_W-1];
  assign x_sn   = is_nan(x_op) && !x_op[MAN_W-1];
  assign y_sn   = is_nan(y_op) && !y_op[MAN_W-1];
  assign z_qn   = is_nan(z_op) && z_op[MAN_W-1];
  assign any_sn = z_sn || x_sn || y_sn;
  assign prod_fin_nz = !(&x_op[W-2:MAN_W]) && !(&y_op[W-2:MAN_W]) &&
                       !is_zero(x_op[W-2:0]) && !is_zero(y_op[W-2:0]);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!special_hit && !invalid_op && special_val == '0));

  // R3
  snan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    z_sn |=> (special_hit && invalid_op && special_val == ($past(z_op) | QB)));

  // R4
  qnan_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (z_qn && !any_sn) |=> (special_hit && !invalid_op && special_val == $past(z_op)));

  // R10
  zinf_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_fin_nz && is_inf(z_op)) |=> (special_hit && !invalid_op && special_val == $past(z_op)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !special_hit |-> (!invalid_op && special_val == '0));

  // R5
  invalid_nan_chk: assert property (@(posedge clk) disable iff (rst)
    invalid_op |-> (special_hit && (&special_val[W-2:MAN_W-1])));
endmodule

bind fma_special_stage fma_special_stage_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .z_op        (z_op),
  .x_op        (x_op),
  .y_op        (y_op),
  .special_hit (special_hit),
  .special_val (special_val),
  .invalid_op  (invalid_op)
);

// File: tb/tb_fma_special_stage.sv
module tb_fma_special_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] z_op = '0, x_op = '0, y_op = '0;
  logic        neg_product = 1'b0, round_neg = 1'b0;
  logic        special_hit, invalid_op;
  logic [31:0] special_val;

  always #5 clk = ~clk;

  fma_special_stage dut (
    .clk(clk), .rst(rst), .z_op(z_op), .x_op(x_op), .y_op(y_op),
    .neg_product(neg_product), .round_neg(round_neg),
    .special_hit(special_hit), .special_val(special_val), .invalid_op(invalid_op)
  );

  localparam logic [31:0] P1 = 32'h3F800000, N2 = 32'hC0000000;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] PZ = 32'h0, NZ = 32'h80000000, DEN = 32'h00000010;
  localparam logic [31:0] QN = 32'h7FC00001, SN = 32'h7F800005, SNN = 32'hFF800011;
  localparam logic [31:0] DNAN = 32'h7FC00000;

  typedef struct {
    logic        hit;
    logic        inv;
    logic [31:0] val;
    string       tag;
    int          cyc;
  } exp_t;

  exp_t q[$];
  int   cycle = 0;
  int   total = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got hit=%0b inv=%0b val=%08h, expected hit=%0b inv=%0b val=%08h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // Reference built from the requirement text: returns {hit, inv, val}.
  function automatic logic [33:0] model(input logic [31:0] z, x, y, input logic ng, rn);
    logic [31:0] o [3];
    logic ps;
    o[0] = z; o[1] = x; o[2] = y;
    for (int i = 0; i < 3; i++)
      if (o[i][30:23] == 8'hFF && o[i][22:0] != 0 && !o[i][22]) return {2'b11, o[i] | 32'h00400000};
    for (int i = 0; i < 3; i++)
      if (o[i][30:23] == 8'hFF && o[i][22]) return {2'b10, o[i]};
    ps = x[31] ^ y[31] ^ ng;
    if (x[30:0] == PINF[30:0] || y[30:0] == PINF[30:0]) begin
      if (x[30:0] == 0 || y[30:0] == 0) return {2'b11, DNAN};
      if (z[30:0] == PINF[30:0] && z[31] != ps) return {2'b11, DNAN};
      return {2'b10, ps, 31'h7F800000};
    end
    if (x[30:0] == 0 || y[30:0] == 0) begin
      if (z[30:0] == 0 && z[31] != ps) return {2'b10, rn, 31'h0};
      return {2'b10, z};
    end
    if (z[30:0] == PINF[30:0]) return {2'b10, z};
    return 34'h0;
  endfunction

  task automatic drive(input logic [31:0] z, x, y, input logic ng, rn, input string tag);
    exp_t e;
    logic [33:0] m;
    @(negedge clk);
    z_op = z; x_op = x; y_op = y; neg_product = ng; round_neg = rn;
    m = model(z, x, y, ng, rn);
    e.hit = m[33]; e.inv = m[32]; e.val = m[31:0]; e.tag = tag; e.cyc = cycle;
    q.push_back(e);
  endtask

  // Monitor: an item issued before the last rising edge is due now.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0 && q[0].cyc < cycle) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {special_hit, invalid_op, special_val}, {e.hit, e.inv, e.val});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got hung, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    z_op = QN; x_op = SN; y_op = PINF;
    repeat (3) @(negedge clk);
    check("R1 reset", {special_hit, invalid_op, special_val}, 34'h0);
    rst = 1'b0;
    // R2 priority
    drive(QN, P1, SN, 0, 0, "R2 snan_y_over_qnan_z");
    drive(P1, SNN, SN, 0, 0, "R2 snan_x_over_snan_y");
    drive(SN, SNN, QN, 0, 0, "R2 snan_z_first");
    // R3
    drive(SN, P1, P1, 0, 0, "R3 snan_quieted");
    // R4
    drive(P1, 32'h7FC00002, QN, 0, 0, "R4 qnan_x_first");
    drive(32'hFFC00003, QN, P1, 0, 0, "R4 qnan_z_first");
    // R5
    drive(P1, PINF, PZ, 0, 0, "R5 inf_times_zero");
    drive(P1, NZ, NINF, 0, 0, "R5 zero_times_inf");
    // R6
    drive(NINF, PINF, P1, 0, 0, "R6 opposite_inf_add");
    drive(PINF, PINF, P1, 1, 0, "R6 opposite_inf_negated");
    // R7
    drive(P1, PINF, N2, 0, 0, "R7 neg_inf");
    drive(P1, PINF, N2, 1, 0, "R7 neg_inf_flipped");
    drive(PINF, NINF, NINF, 0, 0, "R7 same_sign_inf");
    // R8
    drive(NINF, PZ, P1, 0, 0, "R8 z_inf");
    drive(DEN, PZ, P1, 0, 0, "R8 z_denorm");
    drive(N2, P1, NZ, 0, 0, "R8 z_normal");
    // R9
    drive(NZ, PZ, N2, 0, 0, "R9 same_sign_zero");
    drive(PZ, PZ, N2, 0, 0, "R9 cancel_pos");
    drive(PZ, PZ, N2, 0, 1, "R9 cancel_round_neg");
    drive(PZ, PZ, P1, 1, 0, "R9 cancel_negated");
    // R10
    drive(NINF, P1, DEN, 0, 0, "R10 z_inf_finite_prod");
    // R11
    drive(P1, P1, N2, 0, 0, "R11 normal_operands");
    drive(PZ, DEN, DEN, 0, 1, "R11 denorm_operands");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule